// File: doc/BRIEF.md
# Extended-Precision NaN Result Selector

This block decides the result of an 80-bit extended-precision floating-point operation when at least one of its two operands is a NaN or carries an unsupported encoding. Each operand arrives as a sign, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. The block classifies both operands and chooses the NaN to propagate, or substitutes a built-in quiet NaN. It also decides whether the operation raises the invalid-operation exception, and whether the destination may be written given the invalid-operation mask.

One request is accepted per cycle, qualified by `in_vld`. The block registers the result, the write-enable and the exception flags, and presents them one cycle later with `out_vld`. Operations in which neither operand is a NaN or an unsupported encoding belong to the arithmetic path, so the block neither writes a result nor raises a flag for them. Updating the status word from the flags is the consumer's job.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its exponent is 0x7FFF and significand bit 63 is 1. It is quiet when significand bit 62 is 1 and signalling otherwise. Every result written (`res_we`=1) is a NaN with exponent 0x7FFF and bit 63 set.
- R2: An operand whose exponent is 0x7FFF and whose bit 63 is 0 is unsupported. If either operand is unsupported, `inv_evt` is 1 and NaN selection is skipped. When `inv_mask`=1, the built-in quiet NaN is written: sign 1, exponent 0x7FFF, significand 0xC000000000000000.
- R3: When both operands are NaNs, the operand with the larger unsigned 64-bit significand is propagated, sign included.
- R4: When both operands are NaNs with equal significands, the result is the built-in quiet NaN if `tie_pick_b`=0 and operand B if `tie_pick_b`=1, whatever the signs.
- R5: When exactly one operand is a NaN and the other is not unsupported, that NaN is propagated.
- R6: The case is signalling unless every NaN operand is quiet. A signalling case sets `inv_evt`. A quiet case clears `inv_evt` and writes the chosen NaN unchanged.
- R7: In a signalling case with `inv_mask`=1, the chosen NaN is written with bit 62 forced to 1, and `inv_trap` stays 0.
- R8: In a signalling or unsupported case with `inv_mask`=0, `res_we` is 0 and `inv_evt` and `inv_trap` are both 1.
- R9: When neither operand has exponent 0x7FFF, `res_we`, `inv_evt` and `inv_trap` are 0.
- R10: Outputs for a request appear on the cycle after `in_vld`=1, with `out_vld`=1. After a cycle with `in_vld`=0, `out_vld`, `res_we`, `inv_evt` and `inv_trap` are 0.
- R11: While and right after `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request qualifier |
| a_sign | input | 1 | Operand A sign |
| a_exp | input | 15 | Operand A biased exponent |
| a_sig | input | 64 | Operand A significand, bit 63 integer bit |
| b_sign | input | 1 | Operand B sign |
| b_exp | input | 15 | Operand B biased exponent |
| b_sig | input | 64 | Operand B significand, bit 63 integer bit |
| tie_pick_b | input | 1 | On equal NaN significands: 0 gives built-in NaN, 1 gives operand B |
| inv_mask | input | 1 | Invalid-operation exception masked when 1 |
| out_vld | output | 1 | Registered result qualifier |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Result exponent |
| res_sig | output | 64 | Result significand |
| res_we | output | 1 | Destination write enable |
| inv_evt | output | 1 | Invalid-operation exception raised |
| inv_trap | output | 1 | Invalid raised while unmasked |

## Verification
The only state is the one output register stage, so a wrong internal decision shows at the ports on the very next cycle. A misclassified operand or an inverted significand compare shows up as a wrong sign or significand. A misread quiet bit shows up as a wrong `inv_evt` or a missing bit-62 force. Masking errors show as a write or a trap where the opposite was due. Random operands biased toward NaNs, unsupported encodings and equal significands are compared against a bench model on every request. Directed cases pin down the tie rule and the masking corners.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    parameter int EXP_W = 15;
    parameter int SIG_W = 64;
    localparam int INT_BIT   = SIG_W - 1;
    localparam int QUIET_BIT = SIG_W - 2;
    localparam int N_OPS     = 2;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xp_t;

    typedef struct packed {
        logic is_nan;
        logic is_bad;
        logic is_quiet;
    } xp_class_t;

    localparam logic [SIG_W-1:0] DFLT_SIG = {2'b11, {(SIG_W-2){1'b0}}};
    localparam xp_t DFLT_NAN = '{sign: 1'b1, exp: {EXP_W{1'b1}}, sig: DFLT_SIG};

    function automatic logic exp_saturated(input logic [EXP_W-1:0] e);
        return &e;
    endfunction

    function automatic xp_t quieten(input xp_t v);
        xp_t r;
        r = v;
        r.sig[QUIET_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
(
    input  xp_t       op,
    output xp_class_t cls
);
    logic top_exp;

    always_comb begin
        top_exp      = exp_saturated(op.exp);
        cls.is_nan   = top_exp & op.sig[INT_BIT];
        cls.is_bad   = top_exp & ~op.sig[INT_BIT];
        cls.is_quiet = op.sig[QUIET_BIT];
    end
endmodule

// File: rtl/nanprop_choose.sv
module nanprop_choose
    import nanprop_pkg::*;
(
    input  xp_t       op_a,
    input  xp_t       op_b,
    input  xp_class_t cls_a,
    input  xp_class_t cls_b,
    input  logic      tie_pick_b,
    input  logic      inv_mask,
    output xp_t       res,
    output logic      we,
    output logic      evt,
    output logic      trap
);
    xp_t  pick;
    logic sgl;

    always_comb begin
        pick = op_a;
        sgl  = 1'b0;
        if (cls_a.is_nan && cls_b.is_nan) begin
            sgl = ~(cls_a.is_quiet & cls_b.is_quiet);
            if (op_b.sig > op_a.sig)
                pick = op_b;
            else if (op_b.sig == op_a.sig)
                pick = tie_pick_b ? op_b : DFLT_NAN;
            else
                pick = op_a;
        end else if (cls_a.is_nan) begin
            sgl  = ~cls_a.is_quiet;
            pick = op_a;
        end else if (cls_b.is_nan) begin
            sgl  = ~cls_b.is_quiet;
            pick = op_b;
        end
    end

    always_comb begin
        res = DFLT_NAN;
        we  = 1'b0;
        evt = 1'b0;
        if (cls_a.is_bad || cls_b.is_bad) begin
            evt = 1'b1;
            we  = inv_mask;
        end else if (cls_a.is_nan || cls_b.is_nan) begin
            evt = sgl;
            we  = ~sgl | inv_mask;
            res = sgl ? quieten(pick) : pick;
        end
        trap = evt & ~inv_mask;
    end
endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
    import nanprop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic             tie_pick_b,
    input  logic             inv_mask,
    output logic             out_vld,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [SIG_W-1:0] res_sig,
    output logic             res_we,
    output logic             inv_evt,
    output logic             inv_trap
);
    xp_t       ops [N_OPS];
    xp_class_t cls [N_OPS];
    xp_t       res_c, res_q;
    logic      we_c, evt_c, trap_c;
    logic      vld_q, we_q, evt_q, trap_q;

    assign ops[0] = '{sign: a_sign, exp: a_exp, sig: a_sig};
    assign ops[1] = '{sign: b_sign, exp: b_exp, sig: b_sig};

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        nanprop_classify u_cls (
            .op  (ops[g]),
            .cls (cls[g])
        );
    end

    nanprop_choose u_choose (
        .op_a       (ops[0]),
        .op_b       (ops[1]),
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .tie_pick_b (tie_pick_b),
        .inv_mask   (inv_mask),
        .res        (res_c),
        .we         (we_c),
        .evt        (evt_c),
        .trap       (trap_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            we_q   <= 1'b0;
            evt_q  <= 1'b0;
            trap_q <= 1'b0;
            res_q  <= '0;
        end else begin
            vld_q  <= in_vld;
            we_q   <= in_vld & we_c;
            evt_q  <= in_vld & evt_c;
            trap_q <= in_vld & trap_c;
            if (in_vld)
                res_q <= res_c;
        end
    end

    assign out_vld  = vld_q;
    assign res_we   = we_q;
    assign inv_evt  = evt_q;
    assign inv_trap = trap_q;
    assign res_sign = res_q.sign;
    assign res_exp  = res_q.exp;
    assign res_sig  = res_q.sig;
endmodule

// File: rtl/nanprop_sel_chk.sv
module nanprop_sel_chk
    import nanprop_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic             a_sign,
    input logic [EXP_W-1:0] a_exp,
    input logic [SIG_W-1:0] a_sig,
    input logic             b_sign,
    input logic [EXP_W-1:0] b_exp,
    input logic [SIG_W-1:0] b_sig,
    input logic             tie_pick_b,
    input logic             inv_mask,
    input logic             out_vld,
    input logic             res_sign,
    input logic [EXP_W-1:0] res_exp,
    input logic [SIG_W-1:0] res_sig,
    input logic             res_we,
    input logic             inv_evt,
    input logic             inv_trap
);
    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && !res_we && !inv_evt && !inv_trap));

    // R1
    written_is_nan_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (&res_exp && res_sig[INT_BIT]));

    // R7
    masked_sig_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_we && inv_evt) |-> res_sig[QUIET_BIT]);

    // R8
    trap_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        inv_trap |-> (inv_evt && !res_we));

    // R7
    masked_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && inv_mask) |=> !inv_trap);

    // R9
    ordinary_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !(&a_exp) && !(&b_exp)) |=> (!res_we && !inv_evt && !inv_trap));

    // R2
    bad_a_default_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && inv_mask && (&a_exp) && !a_sig[INT_BIT])
        |=> (res_we && inv_evt && res_sign && res_sig == DFLT_SIG));

    // R11
    always @(posedge clk) begin
        if ($past(rst) && rst)
            reset_clear_chk: assert (!out_vld && !res_we && !inv_evt && !inv_trap);
    end

    logic unused_ok;
    assign unused_ok = ^{a_sign, b_sign, b_sig, tie_pick_b};
endmodule

bind nanprop_sel nanprop_sel_chk chk_i (.*);

// File: tb/nanprop_sel_tb_top.sv
module nanprop_sel_tb_top;
    localparam int EW = 15;
    localparam int SW = 64;
    localparam logic [SW-1:0] QNAN_SIG = 64'hC000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [SW-1:0] a_sig = '0, b_sig = '0;
    logic tie_pick_b = 1'b0, inv_mask = 1'b0;
    logic out_vld, res_sign, res_we, inv_evt, inv_trap;
    logic [EW-1:0] res_exp;
    logic [SW-1:0] res_sig;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nanprop_sel dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .tie_pick_b(tie_pick_b), .inv_mask(inv_mask),
        .out_vld(out_vld), .res_sign(res_sign), .res_exp(res_exp),
        .res_sig(res_sig), .res_we(res_we), .inv_evt(inv_evt),
        .inv_trap(inv_trap)
    );

    // Bench model, written from the requirements
    task automatic model(output logic we, output logic evt, output logic trap,
                         output logic [EW+SW:0] res);
        logic an, bn, ab, bb, aq, bq, sg;
        logic [EW+SW:0] dflt, ch;
        dflt = {1'b1, {EW{1'b1}}, QNAN_SIG};
        an = (a_exp == 15'h7FFF) && a_sig[63];
        bn = (b_exp == 15'h7FFF) && b_sig[63];
        ab = (a_exp == 15'h7FFF) && !a_sig[63];
        bb = (b_exp == 15'h7FFF) && !b_sig[63];
        aq = a_sig[62];
        bq = b_sig[62];
        we = 0; evt = 0; res = dflt; sg = 0; ch = dflt;
        if (ab || bb) begin                      // R2
            evt = 1; we = inv_mask;
        end else if (an || bn) begin
            if (an && bn) begin                  // R3 R4
                sg = !(aq && bq);
                if (a_sig > b_sig)      ch = {a_sign, a_exp, a_sig};
                else if (b_sig > a_sig) ch = {b_sign, b_exp, b_sig};
                else                    ch = tie_pick_b ? {b_sign, b_exp, b_sig} : dflt;
            end else if (an) begin               // R5
                sg = !aq; ch = {a_sign, a_exp, a_sig};
            end else begin
                sg = !bq; ch = {b_sign, b_exp, b_sig};
            end
            evt = sg;                            // R6
            we  = !sg || inv_mask;
            if (sg) ch[62] = 1'b1;               // R7
            res = ch;
        end
        trap = evt && !inv_mask;                 // R8
    endtask

    task automatic check(input string req, input logic [EW+SW+4:0] act,
                         input logic [EW+SW+4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input string req);
        logic we, evt, trap;
        logic [EW+SW:0] r;
        model(we, evt, trap, r);
        in_vld = 1'b1;
        @(negedge clk);
        if (!we) r = {1'b0, res_exp, res_sig} & '0;
        check(req,
              {out_vld, res_we, inv_evt, inv_trap,
               we ? {res_sign, res_exp, res_sig} : {(EW+SW+1){1'b0}}},
              {1'b1, we, evt, trap, r});
    endtask

    task automatic set_ops(input logic s_a, input logic [EW-1:0] e_a, input logic [SW-1:0] f_a,
                           input logic s_b, input logic [EW-1:0] e_b, input logic [SW-1:0] f_b,
                           input logic tie, input logic msk);
        a_sign = s_a; a_exp = e_a; a_sig = f_a;
        b_sign = s_b; b_exp = e_b; b_sig = f_b;
        tie_pick_b = tie; inv_mask = msk;
    endtask

    task automatic rand_op(output logic s, output logic [EW-1:0] e, output logic [SW-1:0] f);
        int k;
        k = $urandom % 8;
        s = 1'($urandom);
        f = {$urandom, $urandom};
        if (k < 5) begin
            e = 15'h7FFF; f[63] = 1'b1;
        end else if (k == 5) begin
            e = 15'h7FFF; f[63] = 1'b0;
        end else begin
            e = 15'($urandom % 32'h7FFF);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic s;
        logic [EW-1:0] e;
        logic [SW-1:0] f;
        void'($urandom(32'd20240611));
        // R11 reset state
        set_ops(1, 15'h7FFF, 64'hC000_0000_0000_0001, 0, 0, 0, 0, 1);
        in_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", {out_vld, res_we, inv_evt, inv_trap, res_sign, res_exp, res_sig}, '0);
        rst = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        // R10 idle cycle with NaN on inputs
        check("R10", {out_vld, res_we, inv_evt, inv_trap, {(EW+SW+1){1'b0}}}, '0);

        // R3 larger significand wins, quiet case
        set_ops(0, 15'h7FFF, 64'hC000_0000_0000_0010, 1, 15'h7FFF, 64'hC000_0000_0000_0020, 0, 0);
        apply("R3");
        set_ops(1, 15'h7FFF, 64'hF000_0000_0000_0000, 0, 15'h7FFF, 64'hC000_0000_0000_0000, 0, 0);
        apply("R3");
        // R4 equal significands, default then B
        set_ops(0, 15'h7FFF, 64'hC123_0000_0000_0000, 0, 15'h7FFF, 64'hC123_0000_0000_0000, 0, 0);
        apply("R4");
        set_ops(1, 15'h7FFF, 64'hC123_0000_0000_0000, 0, 15'h7FFF, 64'hC123_0000_0000_0000, 1, 0);
        apply("R4");
        // R5 single NaN
        set_ops(0, 15'h3FFF, 64'h8000_0000_0000_0000, 1, 15'h7FFF, 64'hC000_0000_0000_0077, 0, 0);
        apply("R5");
        // R7 masked signalling, bit 62 forced
        set_ops(1, 15'h7FFF, 64'h8000_0000_0000_0005, 0, 15'h0001, 64'h8000_0000_0000_0000, 0, 1);
        apply("R7");
        // R6 one quiet, one signalling: signalling
        set_ops(0, 15'h7FFF, 64'hC000_0000_0000_0000, 0, 15'h7FFF, 64'h8000_0000_0000_0009, 0, 1);
        apply("R6");
        // R8 unmasked signalling
        set_ops(0, 15'h7FFF, 64'h8000_0000_0000_0001, 0, 0, 0, 0, 0);
        apply("R8");
        // R2 unsupported, masked and unmasked
        set_ops(0, 15'h7FFF, 64'h4000_0000_0000_0000, 0, 15'h7FFF, 64'hC000_0000_0000_0001, 0, 1);
        apply("R2");
        set_ops(0, 15'h0000, 64'h0, 0, 15'h7FFF, 64'h0000_0000_0000_0003, 0, 0);
        apply("R2");
        // R9 ordinary operands
        set_ops(0, 15'h4000, 64'h8000_0000_0000_0000, 1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
        apply("R9");
        // R1 R10 random mix
        for (int i = 0; i < 600; i++) begin
            rand_op(s, e, f); a_sign = s; a_exp = e; a_sig = f;
            rand_op(s, e, f); b_sign = s; b_exp = e; b_sig = f;
            if ($urandom % 6 == 0) b_sig = a_sig;
            tie_pick_b = 1'($urandom);
            inv_mask = 1'($urandom);
            apply("R1");
            if ($urandom % 5 == 0) begin
                in_vld = 1'b0;
                @(negedge clk);
                check("R10", {out_vld, res_we, inv_evt, inv_trap}, 4'b0);
            end
        end
        in_vld = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule